// File: doc/BRIEF.md
# Write-Once Operating Mode Register

This block is the 8-bit operating mode and configuration register of a microcontroller bus interface. While reset is held, it follows three mode-select pins. When reset is released it keeps the last value it sampled, so the pin levels at the rising edge of reset fix the starting mode. The same reset also loads defaults for the clock-stretch, internal-visibility and emulation bits, and these defaults depend on whether the captured mode is special or normal. After reset, software reads and writes the register through a simple select/strobe bus. Each field has its own write permission, and that permission depends on the current mode class.

The special-mode bit (bit 7, 0 = special) is controlled by a three-state machine. FIRST is the state after reset in a special mode. Any write moves it to OPEN, and that write does not change bit 7. OPEN is the state in which bit 7 is still 0. A write with bit 7 set moves it to SHUT. SHUT is the state in which bit 7 is 1, either captured at reset or written. No write leaves SHUT. Only reset leaves it, and reset enters SHUT or FIRST according to the pin.

The two mode bits and the low configuration fields are guarded separately. Each write-once field has its own flag. Decoded mode outputs feed the rest of the bus interface. The visibility output is forced inactive in single-chip modes.

Top module: `opmode_reg`

## Requirements
- R1: On every clock edge with `rst_n` low, bits 7:5 load `pin_smod_n`, `pin_mb`, `pin_ma`. Once `rst_n` is high, later pin changes have no effect on the register.
- R2: Reset loads bits 4:0 (stretch, visibility, reserved, emulation-data, emulation-enable) with 5'b11011 when the captured bit 7 is 0 (special). It loads 5'b00000 when bit 7 is 1 (normal).
- R3: With `sel` high, `rdata` is {special_n, mb, ma, stretch, vis, 0, emd, eme}, where bit 2 always reads 0. With `sel` low, `rdata` is 0. A write happens on the clock edge with `sel` and `wr` both high, and it is visible from the next cycle. A strobe without `sel` changes nothing.
- R4: Bit 7 follows the FIRST/OPEN/SHUT machine. The first write after a special-mode reset leaves bit 7 unchanged. A later write with bit 7 set makes it 1. Once bit 7 is 1, it stays 1 until reset.
- R5: While bit 7 is 0 before a write, mode bits 6:5 take any written value except 2'b10, any number of times. A write of 2'b10 (special peripheral or reserved code) leaves both bits unchanged.
- R6: While bit 7 is 1 before a write, bits 6:5 accept only the first non-2'b10 write. A rejected 2'b10 write does not use up that one write.
- R7: Permissions are judged on bit 7 before the write. Stretch (bit 4), visibility (bit 3) and the emulation pair (bits 1:0) are writable any number of times in special modes. In normal modes each is writable once, counted only from writes made in normal mode.
- R8: Decoded outputs are: `special_o` = !bit7; `single_chip_o` for bits 6:5 = 00; `narrow_o` for 01; `wide_o` for 11; `periph_o` for code 010; `stretch_o`, `emd_o`, `eme_o` equal to their bits. The mode code {bit7, bit6, bit5} is 000 special single-chip, 001 special narrow, 010 special peripheral, 011 special wide, 100 normal single-chip, 101 normal narrow, 111 normal wide, and 110 reserved.
- R9: `vis_en_o` is the visibility bit when the mode is not single-chip, and 0 in either single-chip mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; pins are sampled while low |
| pin_smod_n | input | 1 | Mode pin, 0 selects a special mode |
| pin_mb | input | 1 | Mode pin B |
| pin_ma | input | 1 | Mode pin A |
| sel | input | 1 | Register select |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not selected |
| special_o | output | 1 | Special mode class |
| single_chip_o | output | 1 | Single-chip mode |
| narrow_o | output | 1 | Expanded narrow mode |
| wide_o | output | 1 | Expanded wide mode |
| periph_o | output | 1 | Special peripheral mode |
| vis_en_o | output | 1 | Internal visibility enable, gated |
| stretch_o | output | 1 | Clock-stretch enable |
| emd_o | output | 1 | Emulation data bit |
| eme_o | output | 1 | Emulation enable bit |

## Verification
Reset is applied with each of the seven legal pin codes. The register image and decoded outputs are compared with the special and normal defaults, and pins are then toggled to show that they no longer matter. Directed write sequences separate three behaviours: the ignored first bit-7 write from a plain store, a rejected 2'b10 code from a consumed write-once slot, and special-mode permissions from normal-mode permissions across the moment bit 7 flips. Seeded random byte streams, including unselected strobes and resets, are run against a bench model of the field rules, so that permission ordering errors show up as image mismatches.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

    localparam int DATA_W   = 8;
    localparam int MODE_W   = 3;
    localparam int NUM_LOW  = 3;
    localparam int LOW_MAXW = 2;

    // bit positions that software and neighbours decode
    localparam int BIT_SPEC = 7;
    localparam int BIT_MB   = 6;
    localparam int BIT_MA   = 5;

    localparam logic [1:0] MB_MA_BLOCKED = 2'b10;

    typedef enum logic [MODE_W-1:0] {
        MD_SP_SINGLE = 3'b000,
        MD_SP_NARROW = 3'b001,
        MD_SP_PERIPH = 3'b010,
        MD_SP_WIDE   = 3'b011,
        MD_NM_SINGLE = 3'b100,
        MD_NM_NARROW = 3'b101,
        MD_NM_RSVD   = 3'b110,
        MD_NM_WIDE   = 3'b111
    } mode_e;

    typedef enum logic [1:0] {
        SPC_FIRST = 2'd0,
        SPC_OPEN  = 2'd1,
        SPC_SHUT  = 2'd2
    } spc_state_e;

    // low configuration fields: 0 emulation pair, 1 visibility, 2 stretch
    function automatic int low_lsb(input int idx);
        case (idx)
            0:       return 0;
            1:       return 3;
            default: return 4;
        endcase
    endfunction

    function automatic int low_width(input int idx);
        return (idx == 0) ? 2 : 1;
    endfunction

endpackage

// File: rtl/opmode_spc_fsm.sv
module opmode_spc_fsm
    import opmode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_smod_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic spec_n,
    output logic in_first
);

    spc_state_e state_q;
    spc_state_e state_d;

    // state register; pin sampled while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= pin_smod_n ? SPC_SHUT : SPC_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SPC_FIRST: if (wr_en)           state_d = SPC_OPEN;
            SPC_OPEN:  if (wr_en && wr_bit) state_d = SPC_SHUT;
            SPC_SHUT:                       state_d = SPC_SHUT;
            default:                        state_d = SPC_SHUT;
        endcase
    end

    // outputs
    always_comb begin
        spec_n   = 1'b0;
        in_first = 1'b0;
        unique case (state_q)
            SPC_FIRST: in_first = 1'b1;
            SPC_OPEN:  ;
            SPC_SHUT:  spec_n = 1'b1;
            default:   spec_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/opmode_once_field.sv
module opmode_once_field #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic         anytime,
    input  logic         wr_en,
    input  logic         blocked,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q,
    output logic         done
);

    logic accept;

    assign accept = wr_en && !blocked && (anytime || !done);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= rst_val;
            done <= 1'b0;
        end else if (accept) begin
            q <= wdata;
            if (!anytime) begin
                done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/opmode_decode.sv
module opmode_decode
    import opmode_pkg::*;
(
    input  logic [MODE_W-1:0] code,
    input  logic              vis_bit,
    output logic              special_o,
    output logic              single_chip_o,
    output logic              narrow_o,
    output logic              wide_o,
    output logic              periph_o,
    output logic              vis_en_o
);

    mode_e md;

    assign md = mode_e'(code);

    always_comb begin
        special_o     = 1'b0;
        single_chip_o = 1'b0;
        narrow_o      = 1'b0;
        wide_o        = 1'b0;
        periph_o      = 1'b0;
        unique case (md)
            MD_SP_SINGLE: begin special_o = 1'b1; single_chip_o = 1'b1; end
            MD_SP_NARROW: begin special_o = 1'b1; narrow_o = 1'b1; end
            MD_SP_PERIPH: begin special_o = 1'b1; periph_o = 1'b1; end
            MD_SP_WIDE:   begin special_o = 1'b1; wide_o = 1'b1; end
            MD_NM_SINGLE: single_chip_o = 1'b1;
            MD_NM_NARROW: narrow_o = 1'b1;
            MD_NM_RSVD:   ;
            MD_NM_WIDE:   wide_o = 1'b1;
            default:      ;
        endcase
    end

    assign vis_en_o = vis_bit && !single_chip_o;

endmodule

// File: rtl/opmode_reg.sv
module opmode_reg
    import opmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_smod_n,
    input  logic              pin_mb,
    input  logic              pin_ma,
    input  logic              sel,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              special_o,
    output logic              single_chip_o,
    output logic              narrow_o,
    output logic              wide_o,
    output logic              periph_o,
    output logic              vis_en_o,
    output logic              stretch_o,
    output logic              emd_o,
    output logic              eme_o
);

    logic                wr_en;
    logic                spec_n;
    logic                in_first;
    logic [1:0]          mode_bits;
    logic                mode_done;
    logic                mode_blk;
    logic [LOW_MAXW-1:0] low_q    [NUM_LOW];
    logic                low_done [NUM_LOW];
    logic                rsvd_unused;
    logic                stretch_done;
    logic                vis_bit;
    logic [DATA_W-1:0]   image;

    assign wr_en       = sel && wr;
    assign rsvd_unused = wdata[2];
    assign mode_blk    = (wdata[BIT_MB:BIT_MA] == MB_MA_BLOCKED);

    opmode_spc_fsm u_spc (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_smod_n (pin_smod_n),
        .wr_en      (wr_en),
        .wr_bit     (wdata[BIT_SPEC]),
        .spec_n     (spec_n),
        .in_first   (in_first)
    );

    opmode_once_field #(.W(2)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val ({pin_mb, pin_ma}),
        .anytime (!spec_n),
        .wr_en   (wr_en),
        .blocked (mode_blk),
        .wdata   (wdata[BIT_MB:BIT_MA]),
        .q       (mode_bits),
        .done    (mode_done)
    );

    for (genvar g = 0; g < NUM_LOW; g++) begin : g_low
        localparam int LSB = low_lsb(g);
        localparam int W   = low_width(g);
        logic [W-1:0] q_g;

        opmode_once_field #(.W(W)) u_fld (
            .clk     (clk),
            .rst_n   (rst_n),
            .rst_val ({W{~pin_smod_n}}),
            .anytime (!spec_n),
            .wr_en   (wr_en),
            .blocked (1'b0),
            .wdata   (wdata[LSB +: W]),
            .q       (q_g),
            .done    (low_done[g])
        );

        assign low_q[g] = LOW_MAXW'(q_g);
    end

    assign vis_bit      = low_q[1][0];
    assign stretch_o    = low_q[2][0];
    assign emd_o        = low_q[0][1];
    assign eme_o        = low_q[0][0];
    assign stretch_done = low_done[2];

    assign image = {spec_n, mode_bits, stretch_o, vis_bit, 1'b0, emd_o, eme_o};
    assign rdata = sel ? image : '0;

    opmode_decode u_dec (
        .code          ({spec_n, mode_bits}),
        .vis_bit       (vis_bit),
        .special_o     (special_o),
        .single_chip_o (single_chip_o),
        .narrow_o      (narrow_o),
        .wide_o        (wide_o),
        .periph_o      (periph_o),
        .vis_en_o      (vis_en_o)
    );

endmodule

// File: rtl/opmode_reg_chk.sv
module opmode_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic       wr,
    input logic [7:0] wdata,
    input logic       spec_n,
    input logic       in_first,
    input logic [1:0] mode_bits,
    input logic       mode_done,
    input logic       stretch_done,
    input logic       stretch_o,
    input logic       single_chip_o,
    input logic       vis_en_o
);

    // R4
    spc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spec_n |=> spec_n);

    // R4
    first_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_first && sel && wr) |=> !spec_n);

    // R5
    blocked_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && wdata[6:5] == 2'b10) |=> $stable(mode_bits));

    // R6
    mode_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_n && mode_done && sel && wr) |=> $stable(mode_bits));

    // R7
    stretch_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_n && stretch_done && sel && wr) |=> $stable(stretch_o));

    // R9
    vis_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        single_chip_o |-> !vis_en_o);

endmodule

bind opmode_reg opmode_reg_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel           (sel),
    .wr            (wr),
    .wdata         (wdata),
    .spec_n        (spec_n),
    .in_first      (in_first),
    .mode_bits     (mode_bits),
    .mode_done     (mode_done),
    .stretch_done  (stretch_done),
    .stretch_o     (stretch_o),
    .single_chip_o (single_chip_o),
    .vis_en_o      (vis_en_o)
);

// File: tb/opmode_reg_tb.sv
module opmode_reg_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_smod_n = 1'b0;
    logic       pin_mb = 1'b0;
    logic       pin_ma = 1'b0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       special_o, single_chip_o, narrow_o, wide_o, periph_o;
    logic       vis_en_o, stretch_o, emd_o, eme_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    // model state
    int         m_st;      // 0 first, 1 open, 2 shut
    logic [1:0] m_mm;
    logic       m_estr, m_ivis;
    logic [1:0] m_emx;
    bit         d_mm, d_estr, d_ivis, d_emx;

    always #10 clk = ~clk;

    opmode_reg u_dut (
        .clk(clk), .rst_n(rst_n), .pin_smod_n(pin_smod_n), .pin_mb(pin_mb),
        .pin_ma(pin_ma), .sel(sel), .wr(wr), .wdata(wdata), .rdata(rdata),
        .special_o(special_o), .single_chip_o(single_chip_o),
        .narrow_o(narrow_o), .wide_o(wide_o), .periph_o(periph_o),
        .vis_en_o(vis_en_o), .stretch_o(stretch_o), .emd_o(emd_o), .eme_o(eme_o)
    );

    function automatic logic [7:0] exp_image();
        return {m_st == 2, m_mm, m_estr, m_ivis, 1'b0, m_emx};
    endfunction

    function automatic logic [8:0] exp_dec();
        logic sp, sc;
        sp = (m_st != 2);
        sc = (m_mm == 2'b00);
        return {sp, sc, m_mm == 2'b01, m_mm == 2'b11, sp && m_mm == 2'b10,
                m_ivis && !sc, m_estr, m_emx[1], m_emx[0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        sel = 1'b1; wr = 1'b0;
        #1;
        chk({req, " image"}, 32'(rdata), 32'(exp_image()));
        chk({req, " R8 decode"},
            32'({special_o, single_chip_o, narrow_o, wide_o, periph_o,
                 vis_en_o, stretch_o, emd_o, eme_o}), 32'(exp_dec()));
        sel = 1'b0;
    endtask

    task automatic model_reset(input logic [2:0] p);
        m_st = p[2] ? 2 : 0;
        m_mm = p[1:0];
        {m_estr, m_ivis, m_emx} = p[2] ? 4'b0000 : 4'b1111;
        d_mm = 0; d_estr = 0; d_ivis = 0; d_emx = 0;
    endtask

    task automatic model_write(input logic [7:0] d);
        bit nm;
        nm = (m_st == 2);
        if (d[6:5] != 2'b10 && (!nm || !d_mm)) begin m_mm = d[6:5]; if (nm) d_mm = 1; end
        if (!nm || !d_estr) begin m_estr = d[4]; if (nm) d_estr = 1; end
        if (!nm || !d_ivis) begin m_ivis = d[3]; if (nm) d_ivis = 1; end
        if (!nm || !d_emx)  begin m_emx = d[1:0]; if (nm) d_emx = 1; end
        if (m_st == 0) m_st = 1;
        else if (m_st == 1 && d[7]) m_st = 2;
    endtask

    task automatic do_reset(input logic [2:0] p);
        @(negedge clk);
        rst_n = 1'b0; sel = 1'b0; wr = 1'b0;
        {pin_smod_n, pin_mb, pin_ma} = p;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset(p);
    endtask

    task automatic bus(input logic s, input logic w, input logic [7:0] d);
        @(negedge clk);
        sel = s; wr = w; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        if (s && w) model_write(d);
    endtask

    logic [2:0] legal [7] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b111};

    initial begin
        void'($urandom(32'h00C0FFEE));
        // R1 R2: reset into every legal code, then pins ignored
        for (int i = 0; i < 7; i++) begin
            do_reset(legal[i]);
            check_all("R1 R2 reset");
            {pin_smod_n, pin_mb, pin_ma} = ~legal[i];
            repeat (3) @(negedge clk);
            check_all("R1 pins ignored");
        end
        // R3: unselected read and strobe without select
        do_reset(3'b011);
        sel = 1'b0; #1;
        chk("R3 rdata idle", 32'(rdata), 32'h0);
        bus(1'b0, 1'b1, 8'hFF);
        check_all("R3 unselected strobe");
        // R4 R5: special sequence
        do_reset(3'b001);
        bus(1'b1, 1'b1, 8'hE0);
        check_all("R4 first write ignored");
        chk("R4 bit7 still 0", 32'(special_o), 32'h1);
        bus(1'b1, 1'b1, 8'h40);
        check_all("R5 code 10 rejected");
        bus(1'b1, 1'b1, 8'h00);
        check_all("R5 rewrite special");
        bus(1'b1, 1'b1, 8'hBB);
        check_all("R4 bit7 set");
        chk("R4 normal now", 32'(special_o), 32'h0);
        bus(1'b1, 1'b1, 8'hE0);
        check_all("R6 R7 first normal write");
        bus(1'b1, 1'b1, 8'h3B);
        check_all("R4 R6 R7 second write blocked");
        // R6: rejected code does not consume
        do_reset(3'b100);
        bus(1'b1, 1'b1, 8'hC0);
        check_all("R6 blocked code normal");
        bus(1'b1, 1'b1, 8'hB0);
        check_all("R6 accepted after block");
        bus(1'b1, 1'b1, 8'hE8);
        check_all("R6 R7 locked");
        // R9: visibility gating
        do_reset(3'b000);
        check_all("R9 special single vis off");
        chk("R9 vis off", 32'(vis_en_o), 32'h0);
        do_reset(3'b100);
        bus(1'b1, 1'b1, 8'h88);
        check_all("R9 normal single vis bit set");
        do_reset(3'b011);
        chk("R9 vis on wide", 32'(vis_en_o), 32'h1);
        // random streams
        for (int r = 0; r < 40; r++) begin
            do_reset(legal[$urandom_range(6, 0)]);
            for (int k = 0; k < 12; k++) begin
                logic [7:0] d;
                d = 8'($urandom());
                if ($urandom_range(3, 0) == 0) d[6:5] = 2'b10;
                bus($urandom_range(7, 0) != 0, 1'b1, d);
                check_all("R3 R4 R5 R6 R7 random");
            end
        end
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule